// File: doc/BRIEF.md
# Edge-Configurable External Interrupt Bank

This block collects up to 32 asynchronous external lines and turns them into interrupt requests for a parent interrupt controller. Every line is first brought into the clock domain by a flop chain. A line whose capability bit is 1 is a configurable line. Software chooses rising, falling or both edges for it. A detected edge is latched in a rising-pending or falling-pending bit, and the bit stays set until software clears it by writing 1. A line whose capability bit is 0 is a direct line. Its synchronised level goes straight to its interrupt output, gated only by the interrupt enable.

Software reaches the block through a one-cycle register port. The port has a write strobe, a 4-bit word address and write data one bit per line. Read data is registered and reflects the addressed register one clock later. A write to the software-trigger register makes a configurable line pending exactly as an edge would, which lets a handler retrigger a line. The per-line interrupt outputs are active-high levels. A summary output stays high while any enabled pending line remains, so a handler can loop until the pending status reads zero. A separate event enable produces a one-cycle event pulse each time a configurable line becomes pending.

Top module: `ext_irq_bank`

## Requirements
- R1: After reset, the readable registers read 0, except the capability register at address 8. `irq_line`, `irq_sum` and `evt_out` are all 0.
- R2: On a configurable line whose rising-select bit (address 2) is 1, a 0-to-1 change of the synchronised input sets the rising-pending bit (address 5). A falling change does not set it.
- R3: On a configurable line whose falling-select bit (address 3) is 1, a 1-to-0 change sets the falling-pending bit (address 6). With both select bits set, either direction sets the matching pending bit.
- R4: A write to address 5 or 6 clears exactly the pending bits whose data bit is 1. Bits written 0 keep their value.
- R5: If a new edge and a clearing write hit the same pending bit in the same cycle, the bit remains set.
- R6: Writing 1s to address 4 sets the rising-pending bits of those configurable lines. The write has no effect on direct lines, and address 4 reads 0.
- R7: For a configurable line, `irq_line` bit n is high while (rising-pending OR falling-pending) AND interrupt-enable bit n (address 0) are both 1. A disabled line keeps its pending bit but drives 0.
- R8: For a direct line, `irq_line` follows the synchronised input ANDed with its interrupt-enable bit, and its pending bits stay 0.
- R9: `irq_sum` is 1 exactly when any bit of `irq_line` is 1.
- R10: When a configurable line becomes pending and its event-enable bit (address 1) is 1, `evt_out` bit n is high for exactly one cycle.
- R11: The capability register (address 8, 1 = configurable) ignores writes. The select bits of direct lines read 0 and ignore writes.
- R12: Address 7 reads the OR of the rising-pending and falling-pending registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Word address of register |
| bus_wdata | input | NUM_LINES | Write data, one bit per line |
| bus_rdata | output | NUM_LINES | Registered read data for previous cycle's address |
| ext_in | input | NUM_LINES | Asynchronous external lines |
| irq_line | output | NUM_LINES | Per-line active-high interrupt level |
| irq_sum | output | 1 | OR of all interrupt lines |
| evt_out | output | NUM_LINES | One-cycle event pulse per line |

## Verification
The bench aims at the cycle where a clearing write meets a fresh edge on the same bit. A design in which the clear has priority would silently drop that interrupt. It checks that a clear word touches only its 1 bits, which catches a design that clears the whole register or needs a read-modify-write. It drives select writes and trigger writes at direct lines and checks that they leave no pending bit and no readable select bit, and that direct lines still track their pin. Randomised edge directions against random select modes catch swapped rising and falling detection, and the check on masked-but-pending lines catches an interrupt output that ignores the enable.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_IEN   = 4'd0,
    A_EEN   = 4'd1,
    A_RSEL  = 4'd2,
    A_FSEL  = 4'd3,
    A_SWT   = 4'd4,
    A_RPEND = 4'd5,
    A_FPEND = 4'd6,
    A_PSTAT = 4'd7,
    A_CAP   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STAGES <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= din;
      end
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], din};
      end
      assign dout = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned     N   = 32,
  parameter logic [N-1:0]    CAP = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      rise_pend,
  input  logic [N-1:0]      fall_pend,
  output logic [N-1:0]      ien,
  output logic [N-1:0]      een,
  output logic [N-1:0]      rsel,
  output logic [N-1:0]      fsel,
  output logic [N-1:0]      swt,
  output logic [N-1:0]      rclr,
  output logic [N-1:0]      fclr,
  output logic [N-1:0]      rdata
);
  logic [N-1:0] rd_nxt;

  // strobes derived from one decoded write
  assign swt  = (we && addr == A_SWT)   ? (wdata & CAP) : '0;
  assign rclr = (we && addr == A_RPEND) ? wdata : '0;
  assign fclr = (we && addr == A_FPEND) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien  <= '0;
      een  <= '0;
      rsel <= '0;
      fsel <= '0;
    end else if (we) begin
      case (addr)
        A_IEN:   ien  <= wdata;
        A_EEN:   een  <= wdata;
        A_RSEL:  rsel <= wdata & CAP;
        A_FSEL:  fsel <= wdata & CAP;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_IEN:   rd_nxt = ien;
      A_EEN:   rd_nxt = een;
      A_RSEL:  rd_nxt = rsel;
      A_FSEL:  rd_nxt = fsel;
      A_RPEND: rd_nxt = rise_pend;
      A_FPEND: rd_nxt = fall_pend;
      A_PSTAT: rd_nxt = rise_pend | fall_pend;
      A_CAP:   rd_nxt = CAP;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
  parameter int unsigned  N   = 32,
  parameter logic [N-1:0] CAP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rsel,
  input  logic [N-1:0] fsel,
  input  logic [N-1:0] swt,
  input  logic [N-1:0] rclr,
  input  logic [N-1:0] fclr,
  output logic [N-1:0] rise_set,
  output logic [N-1:0] fall_set,
  output logic [N-1:0] rise_pend,
  output logic [N-1:0] fall_pend
);
  logic [N-1:0] prev;
  logic [N-1:0] up_edge;
  logic [N-1:0] dn_edge;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign up_edge  = lvl & ~prev;
  assign dn_edge  = ~lvl & prev;
  assign rise_set = ((up_edge & rsel) | swt) & CAP;
  assign fall_set = (dn_edge & fsel) & CAP;

  // set beats clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_pend <= '0;
      fall_pend <= '0;
    end else begin
      rise_pend <= (rise_set | (rise_pend & ~rclr)) & CAP;
      fall_pend <= (fall_set | (fall_pend & ~fclr)) & CAP;
    end
  end
endmodule

// File: rtl/ext_irq_out.sv
module ext_irq_out #(
  parameter int unsigned  N   = 32,
  parameter logic [N-1:0] CAP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] een,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] new_pend,
  output logic [N-1:0] irq_line,
  output logic         irq_sum,
  output logic [N-1:0] evt_out
);
  logic [N-1:0] irq_nxt;

  assign irq_nxt = ((pend & CAP) | (lvl & ~CAP)) & ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line <= '0;
      irq_sum  <= 1'b0;
      evt_out  <= '0;
    end else begin
      irq_line <= irq_nxt;
      irq_sum  <= |irq_nxt;
      evt_out  <= new_pend & een;
    end
  end
endmodule

// File: rtl/ext_irq_bank.sv
module ext_irq_bank
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned NUM_DIRECT  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] ext_in,
  output logic [NUM_LINES-1:0] irq_line,
  output logic                 irq_sum,
  output logic [NUM_LINES-1:0] evt_out
);
  // the top NUM_DIRECT lines are direct, the rest configurable
  localparam logic [NUM_LINES-1:0] CAP_MASK = {NUM_LINES{1'b1}} >> NUM_DIRECT;

  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] ien, een, rsel, fsel, swt, rclr, fclr;
  logic [NUM_LINES-1:0] rise_set, fall_set, rise_pend, fall_pend;

  ext_irq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .dout(lvl)
  );

  ext_irq_regs #(.N(NUM_LINES), .CAP(CAP_MASK)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rise_pend(rise_pend), .fall_pend(fall_pend),
    .ien(ien), .een(een), .rsel(rsel), .fsel(fsel),
    .swt(swt), .rclr(rclr), .fclr(fclr), .rdata(bus_rdata)
  );

  ext_irq_pend #(.N(NUM_LINES), .CAP(CAP_MASK)) u_pend (
    .clk(clk), .rst(rst), .lvl(lvl), .rsel(rsel), .fsel(fsel), .swt(swt),
    .rclr(rclr), .fclr(fclr), .rise_set(rise_set), .fall_set(fall_set),
    .rise_pend(rise_pend), .fall_pend(fall_pend)
  );

  ext_irq_out #(.N(NUM_LINES), .CAP(CAP_MASK)) u_out (
    .clk(clk), .rst(rst), .lvl(lvl), .ien(ien), .een(een),
    .pend(rise_pend | fall_pend), .new_pend(rise_set | fall_set),
    .irq_line(irq_line), .irq_sum(irq_sum), .evt_out(evt_out)
  );
endmodule

// File: rtl/ext_irq_bank_chk.sv
module ext_irq_bank_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned  N   = 32,
  parameter logic [N-1:0] CAP = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      rise_set,
  input logic [N-1:0]      rise_pend,
  input logic [N-1:0]      fall_pend,
  input logic [N-1:0]      irq_line,
  input logic              irq_sum
);
  // R4: cleared bits with no concurrent set are low after the write
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_RPEND) |=>
      ((rise_pend & $past(bus_wdata & ~rise_set)) == '0));

  // R4: without set or clear the rising-pending word holds
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!(bus_we && bus_addr == A_RPEND) && rise_set == '0) |=> $stable(rise_pend));

  // R5: a set always lands, even against a clear
  p_edge_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (rise_set != '0) |=> ((rise_pend & $past(rise_set)) == $past(rise_set)));

  // R8: direct lines never hold pending state
  p_direct_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (((rise_pend | fall_pend) & ~CAP) == '0));

  // R9: summary agrees with the line vector
  p_sum_r9: assert property (@(posedge clk) disable iff (rst)
    irq_sum == (irq_line != '0));
endmodule

bind ext_irq_bank ext_irq_bank_chk #(.N(NUM_LINES), .CAP(CAP_MASK)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rise_set(rise_set), .rise_pend(rise_pend),
  .fall_pend(fall_pend), .irq_line(irq_line), .irq_sum(irq_sum)
);

// File: tb/tb_ext_irq_bank.sv
`timescale 1ns/1ps
module tb_ext_irq_bank;
  localparam int N    = 32;
  localparam int NDIR = 8;
  localparam int NCFG = N - NDIR;
  localparam logic [N-1:0] CAPV = {N{1'b1}} >> NDIR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, ext_in, irq_line, evt_out;
  logic irq_sum;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ext_irq_bank #(.NUM_LINES(N), .NUM_DIRECT(NDIR), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .irq_line(irq_line), .irq_sum(irq_sum), .evt_out(evt_out)
  );

  function automatic logic [1:0] exp_pend(logic rs, logic fs, logic now_high);
    return {fs & ~now_high, rs & now_high};  // {fall, rise}
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    ext_in = '0;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irq_line", irq_line, '0);
    chk("R1 irq_sum", {{(N-1){1'b0}}, irq_sum}, '0);
    chk("R1 evt_out", evt_out, '0);
    rd(4'd0, v); chk("R1 ien", v, '0);
    rd(4'd5, v); chk("R1 rpend", v, '0);
    rd(4'd8, v); chk("R11 cap value", v, CAPV);

    // R11 read-only cap, direct select bits
    wr(4'd8, '0);  rd(4'd8, v); chk("R11 cap write ignored", v, CAPV);
    wr(4'd2, '1);  rd(4'd2, v); chk("R11 rsel direct bits", v, CAPV);
    wr(4'd3, '1);  rd(4'd3, v); chk("R11 fsel direct bits", v, CAPV);
    wr(4'd2, '0);  wr(4'd3, '0);

    // R6 software trigger
    wr(4'd4, '1);
    rd(4'd5, v); chk("R6 swt sets cfg rpend", v, CAPV);
    rd(4'd6, v); chk("R6 swt leaves fpend", v, '0);
    rd(4'd4, v); chk("R6 swt reads zero", v, '0);

    // R4 selective clear, R12 status
    wr(4'd5, 32'h0000_0005);
    rd(4'd5, v); chk("R4 w1c selective", v, CAPV & ~32'h5);
    rd(4'd7, v); chk("R12 pstat", v, CAPV & ~32'h5);

    // R7 masked pending, then enabled
    idle(3); chk("R7 masked line low", irq_line, '0);
    wr(4'd0, 32'h0000_0010); idle(2);
    chk("R7 enabled pending line", irq_line, 32'h10);
    chk("R9 sum high", {{(N-1){1'b0}}, irq_sum}, 32'h1);
    wr(4'd5, '1); idle(2);
    chk("R7 cleared line low", irq_line, '0);
    chk("R9 sum low", {{(N-1){1'b0}}, irq_sum}, '0);

    // R10 event pulse
    wr(4'd1, 32'h8);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h8;
    @(posedge clk); @(negedge clk); bus_we = 1'b0;
    chk("R10 evt pulse high", evt_out, 32'h8);
    @(posedge clk); @(negedge clk);
    chk("R10 evt pulse gone", evt_out, '0);
    wr(4'd5, '1); wr(4'd1, '0);

    // R8 direct line
    wr(4'd0, 32'h1000_0000);
    wr(4'd4, 32'h1000_0000);
    @(negedge clk) ext_in[28] = 1'b1; idle(5);
    chk("R8 direct follows pin", irq_line, 32'h1000_0000);
    rd(4'd7, v); chk("R8 direct no pending", v, '0);
    @(negedge clk) ext_in[28] = 1'b0; idle(5);
    chk("R8 direct falls with pin", irq_line, '0);
    wr(4'd0, '0);

    // R5 edge beats clear on line 2
    wr(4'd2, 32'h4);
    wr(4'd4, 32'h4);
    @(negedge clk) ext_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h4;
    @(posedge clk); @(negedge clk); bus_we = 1'b0;
    rd(4'd5, v); chk("R5 edge wins over clear", v, 32'h4);
    wr(4'd5, 32'h4);
    rd(4'd5, v); chk("R4 plain clear", v, '0);
    @(negedge clk) ext_in[2] = 1'b0; idle(4);
    rd(4'd5, v); chk("R2 falling ignored on rise-only", v, '0);
    wr(4'd2, '0);

    // R2/R3 random edges and modes
    for (int it = 0; it < 16; it++) begin
      int ln;
      logic [1:0] md, e;
      logic nl;
      ln = int'($urandom % NCFG);
      md = 2'($urandom % 3 + 1);
      wr(4'd2, md[0] ? (32'h1 << ln) : '0);
      wr(4'd3, md[1] ? (32'h1 << ln) : '0);
      idle(4);
      wr(4'd5, '1); wr(4'd6, '1);
      nl = ~ext_in[ln];
      @(negedge clk) ext_in[ln] = nl;
      idle(6);
      e = exp_pend(md[0], md[1], nl);
      rd(4'd5, v); chk("R2 random rise pend", v, e[0] ? (32'h1 << ln) : '0);
      rd(4'd6, v); chk("R3 random fall pend", v, e[1] ? (32'h1 << ln) : '0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule